// File: doc/BRIEF.md
# TLB Refill Victim Selector

This block decides which translation-buffer slot a hardware page-table refill overwrites. The buffer has two parts. One is a set-associative array of pages at one fixed size, organised as ways times sets. The other is a small fully associative array that holds pages of any other size. A refill whose page size equals the fixed size must land in the set-associative part, in the set picked by its address. Any other refill lands somewhere in the fully associative part.

Inside the chosen part the selector looks for the cheapest slot to lose. An entry that is not in use is the best choice, and the lowest-numbered one is taken. Failing that, it takes a valid, non-global entry that belongs to another address space. When several such entries exist, the highest-numbered one is taken. When no slot of either kind exists, a pseudo-random slot is used. The surrounding logic presents the valid, global and address-space fields of every candidate, and the selector reports the chosen index one cycle after the request. The invalidate and write that follow are done elsewhere.

The set-associative candidates are presented through a combinational set lookup. The block drives the set number from the request's address, and the environment returns that set's per-way fields in the same cycle.

Top module: `tlb_victim_sel`

## Requirements
- R1: While reset is asserted and after it, until the first request, `doneValid` is 0 and `victimIdx` is 0.
- R2: `doneValid` is 1 in exactly the cycle after each cycle in which `reqValid` is 1, and it is 0 otherwise.
- R3: `lookupSet` equals `entryHi` shifted right by `fixedPs + 1`, keeping the low log2(SETS) bits (0 to 255 by default). It follows the inputs in the same cycle.
- R4: When `refillPs` equals `fixedPs`, the result is `way*SETS + set`, so it lies below WAYS*SETS (2048), with the set taken from R3. Otherwise the result is WAYS*SETS + i for a fully associative entry i, below WAYS*SETS + FA_DEPTH.
- R5: In the set-associative part, the lowest way whose valid bit is 0 is chosen, even when another way qualifies under R6.
- R6: In the set-associative part with all ways valid, the highest way with global = 0 and an address-space ID different from `curAsid` is chosen.
- R7: A global entry is never preferred under R6, whatever its address-space ID. Neither is a non-global entry whose ID equals `curAsid`.
- R8: The fully associative part follows the same order: first the lowest entry with valid = 0, then the highest valid, non-global entry of a foreign ID.
- R9: With no entry qualifying under R5, R6 or R8, the way comes from the low log2(WAYS) bits of a free-running 16-bit LFSR. The LFSR has polynomial x^16+x^14+x^13+x^11+1 and is seeded to 0xACE1 at reset. The fully associative entry comes from its low bits, reduced into 0..FA_DEPTH-1 by one conditional subtraction. Successive random picks vary.
- R10: `victimIdx` keeps its value in every cycle that follows a cycle without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Refill request, one cycle per refill |
| entryHi | input | VA_W (48) | Virtual address of the page being refilled |
| refillPs | input | PS_W (6) | Page-size exponent of the refill |
| fixedPs | input | PS_W (6) | Page-size exponent of the set-associative part |
| curAsid | input | ASID_W (10) | Current address-space ID |
| lookupSet | output | log2(SETS) (8) | Set whose way fields must be presented |
| saValid | input | WAYS (8) | Valid bit of each way in `lookupSet` |
| saGlobal | input | WAYS (8) | Global bit of each way in `lookupSet` |
| saAsid | input | WAYS*ASID_W (80) | Address-space ID of each way, way 0 in the low bits |
| faValid | input | FA_DEPTH (48) | Valid bit of each fully associative entry |
| faGlobal | input | FA_DEPTH (48) | Global bit of each fully associative entry |
| faAsid | input | FA_DEPTH*ASID_W (480) | Address-space ID of each entry, entry 0 in the low bits |
| doneValid | output | 1 | Result pulse, one cycle after the request |
| victimIdx | output | IDX_W (12) | Index of the slot to overwrite |

## Verification
The properties assume that the candidate fields are held stable in the request cycle. They also assume that the set-associative fields belong to the set the block is driving on `lookupSet` at that moment. The properties compare the registered result against the previous cycle's inputs. The bench drives every request and its field views together on the falling edge, holds them through the next rising edge, and changes them only when the next scenario starts. It never makes the random branch depend on stale views.

// File: rtl/tlb_victim_sel_pkg.sv
package tlb_victim_sel_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadResult;  // register the scan result this cycle
    logic stepRand;    // advance the pseudo-random source
  } vselStrobe_t;

  localparam logic [15:0] RAND_SEED = 16'hACE1;

endpackage

// File: rtl/tlb_victim_scan.sv
// Priority scan over N candidates: lowest empty slot, and the highest
// valid non-global slot of a foreign address space.
module tlb_victim_scan #(
  parameter int N      = 8,
  parameter int ASID_W = 10,
  localparam int IW    = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]        candValid,
  input  logic [N-1:0]        candGlobal,
  input  logic [N*ASID_W-1:0] candAsid,
  input  logic [ASID_W-1:0]   curAsid,
  output logic                hasEmpty,
  output logic [IW-1:0]       emptyIdx,
  output logic                hasForeign,
  output logic [IW-1:0]       foreignIdx
);

  always_comb begin
    hasEmpty = 1'b0;
    emptyIdx = '0;
    for (int i = 0; i < N; i++) begin
      if (!hasEmpty && !candValid[i]) begin
        hasEmpty = 1'b1;
        emptyIdx = IW'(i);
      end
    end
  end

  always_comb begin
    hasForeign = 1'b0;
    foreignIdx = '0;
    for (int i = 0; i < N; i++) begin
      if (candValid[i] && !candGlobal[i] &&
          (candAsid[i*ASID_W +: ASID_W] != curAsid)) begin
        hasForeign = 1'b1;
        foreignIdx = IW'(i);
      end
    end
  end

endmodule

// File: rtl/tlb_victim_ctrl.sv
module tlb_victim_ctrl
  import tlb_victim_sel_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output vselStrobe_t strobe,
  output logic        doneValid
);

  logic runEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runEn     <= 1'b0;
      doneValid <= 1'b0;
    end else begin
      runEn     <= 1'b1;
      doneValid <= reqValid;
    end
  end

  always_comb begin
    strobe.loadResult = reqValid;
    strobe.stepRand   = runEn;
  end

endmodule

// File: rtl/tlb_victim_dp.sv
module tlb_victim_dp
  import tlb_victim_sel_pkg::*;
#(
  parameter int VA_W     = 48,
  parameter int PS_W     = 6,
  parameter int ASID_W   = 10,
  parameter int WAYS     = 8,
  parameter int SETS     = 256,
  parameter int FA_DEPTH = 48,
  localparam int WAY_W    = $clog2(WAYS),
  localparam int SET_W    = $clog2(SETS),
  localparam int FA_W     = $clog2(FA_DEPTH),
  localparam int SA_TOTAL = WAYS * SETS,
  localparam int IDX_W    = $clog2(SA_TOTAL + FA_DEPTH)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  vselStrobe_t               strobe,
  input  logic [VA_W-1:0]           entryHi,
  input  logic [PS_W-1:0]           refillPs,
  input  logic [PS_W-1:0]           fixedPs,
  input  logic [ASID_W-1:0]         curAsid,
  output logic [SET_W-1:0]          lookupSet,
  input  logic [WAYS-1:0]           saValid,
  input  logic [WAYS-1:0]           saGlobal,
  input  logic [WAYS*ASID_W-1:0]    saAsid,
  input  logic [FA_DEPTH-1:0]       faValid,
  input  logic [FA_DEPTH-1:0]       faGlobal,
  input  logic [FA_DEPTH*ASID_W-1:0] faAsid,
  output logic [IDX_W-1:0]          victimIdx
);

  // Set selection from the address
  logic [PS_W:0] setShift;
  assign setShift  = {1'b0, fixedPs} + {{PS_W{1'b0}}, 1'b1};
  assign lookupSet = SET_W'(entryHi >> setShift);

  // Pseudo-random source
  logic [15:0] randReg;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      randReg <= RAND_SEED;
    end else if (strobe.stepRand) begin
      randReg <= {randReg[14:0], randReg[15] ^ randReg[13] ^ randReg[12] ^ randReg[10]};
    end
  end

  logic [WAY_W-1:0] randWay;
  logic [FA_W-1:0]  randFa;
  assign randWay = randReg[WAY_W-1:0];

  generate
    if ((FA_DEPTH & (FA_DEPTH - 1)) == 0) begin : g_faPow2
      assign randFa = randReg[FA_W-1:0];
    end else begin : g_faWrap
      logic [FA_W-1:0] rawFa;
      assign rawFa  = randReg[FA_W-1:0];
      assign randFa = (rawFa >= FA_W'(FA_DEPTH)) ? (rawFa - FA_W'(FA_DEPTH)) : rawFa;
    end
  endgenerate

  // Candidate scans
  logic             saEmpty, saForeign, faEmpty, faForeign;
  logic [WAY_W-1:0] saEmptyWay, saForeignWay;
  logic [FA_W-1:0]  faEmptyIdx, faForeignIdx;

  tlb_victim_scan #(.N(WAYS), .ASID_W(ASID_W)) saScan_i (
    .candValid (saValid),
    .candGlobal(saGlobal),
    .candAsid  (saAsid),
    .curAsid   (curAsid),
    .hasEmpty  (saEmpty),
    .emptyIdx  (saEmptyWay),
    .hasForeign(saForeign),
    .foreignIdx(saForeignWay)
  );

  tlb_victim_scan #(.N(FA_DEPTH), .ASID_W(ASID_W)) faScan_i (
    .candValid (faValid),
    .candGlobal(faGlobal),
    .candAsid  (faAsid),
    .curAsid   (curAsid),
    .hasEmpty  (faEmpty),
    .emptyIdx  (faEmptyIdx),
    .hasForeign(faForeign),
    .foreignIdx(faForeignIdx)
  );

  // Victim choice
  logic             useSa;
  logic [WAY_W-1:0] saPick;
  logic [FA_W-1:0]  faPick;
  logic [IDX_W-1:0] nextVictim;

  assign useSa = (refillPs == fixedPs);

  always_comb begin
    if (saEmpty)        saPick = saEmptyWay;
    else if (saForeign) saPick = saForeignWay;
    else                saPick = randWay;

    if (faEmpty)        faPick = faEmptyIdx;
    else if (faForeign) faPick = faForeignIdx;
    else                faPick = randFa;

    if (useSa) nextVictim = IDX_W'({saPick, lookupSet});
    else       nextVictim = IDX_W'(SA_TOTAL) + IDX_W'(faPick);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      victimIdx <= '0;
    end else if (strobe.loadResult) begin
      victimIdx <= nextVictim;
    end
  end

endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel
  import tlb_victim_sel_pkg::*;
#(
  parameter int VA_W     = 48,
  parameter int PS_W     = 6,
  parameter int ASID_W   = 10,
  parameter int WAYS     = 8,
  parameter int SETS     = 256,
  parameter int FA_DEPTH = 48,
  localparam int SET_W    = $clog2(SETS),
  localparam int IDX_W    = $clog2(WAYS * SETS + FA_DEPTH)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic [VA_W-1:0]            entryHi,
  input  logic [PS_W-1:0]            refillPs,
  input  logic [PS_W-1:0]            fixedPs,
  input  logic [ASID_W-1:0]          curAsid,
  output logic [SET_W-1:0]           lookupSet,
  input  logic [WAYS-1:0]            saValid,
  input  logic [WAYS-1:0]            saGlobal,
  input  logic [WAYS*ASID_W-1:0]     saAsid,
  input  logic [FA_DEPTH-1:0]        faValid,
  input  logic [FA_DEPTH-1:0]        faGlobal,
  input  logic [FA_DEPTH*ASID_W-1:0] faAsid,
  output logic                       doneValid,
  output logic [IDX_W-1:0]           victimIdx
);

  vselStrobe_t strobe;

  tlb_victim_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .strobe   (strobe),
    .doneValid(doneValid)
  );

  tlb_victim_dp #(
    .VA_W(VA_W), .PS_W(PS_W), .ASID_W(ASID_W),
    .WAYS(WAYS), .SETS(SETS), .FA_DEPTH(FA_DEPTH)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .entryHi  (entryHi),
    .refillPs (refillPs),
    .fixedPs  (fixedPs),
    .curAsid  (curAsid),
    .lookupSet(lookupSet),
    .saValid  (saValid),
    .saGlobal (saGlobal),
    .saAsid   (saAsid),
    .faValid  (faValid),
    .faGlobal (faGlobal),
    .faAsid   (faAsid),
    .victimIdx(victimIdx)
  );

endmodule

// File: rtl/tlb_victim_sel_chk.sv
module tlb_victim_sel_chk #(
  parameter int PS_W     = 6,
  parameter int WAYS     = 8,
  parameter int SETS     = 256,
  parameter int FA_DEPTH = 48,
  localparam int SET_W    = $clog2(SETS),
  localparam int WAY_W    = $clog2(WAYS),
  localparam int SA_TOTAL = WAYS * SETS,
  localparam int IDX_W    = $clog2(SA_TOTAL + FA_DEPTH)
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic [PS_W-1:0]     refillPs,
  input logic [PS_W-1:0]     fixedPs,
  input logic [SET_W-1:0]    lookupSet,
  input logic [WAYS-1:0]     saValid,
  input logic [FA_DEPTH-1:0] faValid,
  input logic                doneValid,
  input logic [IDX_W-1:0]    victimIdx
);

  logic             useSaNow;
  logic [WAY_W-1:0] victimWay;
  logic [IDX_W-1:0] faOffset;
  assign useSaNow  = (refillPs == fixedPs);
  assign victimWay = victimIdx[SET_W +: WAY_W];
  assign faOffset  = victimIdx - IDX_W'(SA_TOTAL);

  // R2
  done_after_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> doneValid);

  // R2
  done_only_after_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !doneValid);

  // R4
  sa_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && useSaNow) |=> (victimIdx < IDX_W'(SA_TOTAL)) &&
                               (victimIdx[SET_W-1:0] == $past(lookupSet)));

  // R4
  fa_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !useSaNow) |=> (victimIdx >= IDX_W'(SA_TOTAL)) &&
                                (victimIdx < IDX_W'(SA_TOTAL + FA_DEPTH)));

  // R5
  sa_empty_pref_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && useSaNow && !(&saValid)) |=>
      (($past(saValid) & (WAYS'(1) << victimWay)) == '0));

  // R8
  fa_empty_pref_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !useSaNow && !(&faValid)) |=>
      (($past(faValid) & (FA_DEPTH'(1) << faOffset)) == '0));

  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> $stable(victimIdx));

endmodule

bind tlb_victim_sel tlb_victim_sel_chk #(
  .PS_W(PS_W), .WAYS(WAYS), .SETS(SETS), .FA_DEPTH(FA_DEPTH)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .refillPs (refillPs),
  .fixedPs  (fixedPs),
  .lookupSet(lookupSet),
  .saValid  (saValid),
  .faValid  (faValid),
  .doneValid(doneValid),
  .victimIdx(victimIdx)
);

// File: tb/tlb_victim_sel_tb_top.sv
module tlb_victim_sel_tb_top;

  localparam int VA_W     = 48;
  localparam int PS_W     = 6;
  localparam int ASID_W   = 10;
  localparam int WAYS     = 8;
  localparam int SETS     = 256;
  localparam int FA_DEPTH = 48;
  localparam int SA_TOTAL = WAYS * SETS;
  localparam int IDX_W    = $clog2(SA_TOTAL + FA_DEPTH);

  logic                       clk = 1'b0;
  logic                       rstN;
  logic                       reqValid;
  logic [VA_W-1:0]            entryHi;
  logic [PS_W-1:0]            refillPs, fixedPs;
  logic [ASID_W-1:0]          curAsid;
  logic [7:0]                 lookupSet;
  logic [WAYS-1:0]            saValid, saGlobal;
  logic [WAYS*ASID_W-1:0]     saAsid;
  logic [FA_DEPTH-1:0]        faValid, faGlobal;
  logic [FA_DEPTH*ASID_W-1:0] faAsid;
  logic                       doneValid;
  logic [IDX_W-1:0]           victimIdx;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  tlb_victim_sel dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .entryHi(entryHi),
    .refillPs(refillPs), .fixedPs(fixedPs), .curAsid(curAsid),
    .lookupSet(lookupSet), .saValid(saValid), .saGlobal(saGlobal),
    .saAsid(saAsid), .faValid(faValid), .faGlobal(faGlobal),
    .faAsid(faAsid), .doneValid(doneValid), .victimIdx(victimIdx)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expSet(input logic [VA_W-1:0] va, input int ps);
    return int'((va >> (ps + 1)) & 48'hFF);
  endfunction

  // All views valid, non-global, owned by the current ID
  task automatic setHome();
    saValid  = '1; saGlobal = '0;
    faValid  = '1; faGlobal = '0;
    for (int w = 0; w < WAYS; w++) saAsid[w*ASID_W +: ASID_W] = curAsid;
    for (int e = 0; e < FA_DEPTH; e++) faAsid[e*ASID_W +: ASID_W] = curAsid;
  endtask

  // Drive one request on the falling edge; return sampled result one cycle later
  task automatic refill(output logic done, output int idx);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    done = doneValid;
    idx  = int'(victimIdx);
  endtask

  task automatic tReset();
    @(negedge clk);
    check("R1 done after reset", doneValid, 0);
    check("R1 index after reset", victimIdx, 0);
  endtask

  task automatic tSetIndex();
    logic d; int idx;
    fixedPs = 6'd13; refillPs = 6'd13;
    entryHi = 48'h0000_1234_5678_9ABC;
    #0.5;
    check("R3 lookupSet ps13", lookupSet, expSet(entryHi, 13));
    fixedPs = 6'd21; refillPs = 6'd21;
    #0.5;
    check("R3 lookupSet ps21", lookupSet, expSet(entryHi, 21));
    setHome();
    saValid[6] = 1'b0;
    @(negedge clk);
    refill(d, idx);
    check("R2 done pulse", d, 1);
    check("R4 set-assoc index", idx, 6 * SETS + expSet(entryHi, 21));
    @(negedge clk);
    check("R2 done drops", doneValid, 0);
  endtask

  task automatic tSaEmpty();
    logic d; int idx;
    fixedPs = 6'd13; refillPs = 6'd13; entryHi = 48'h0000_0000_00AB_C000;
    setHome();
    saValid = 8'b1101_0111;
    saAsid[1*ASID_W +: ASID_W] = curAsid + 10'd1;
    @(negedge clk);
    refill(d, idx);
    check("R5 lowest empty way", idx, 3 * SETS + expSet(entryHi, 13));
  endtask

  task automatic tSaForeign();
    logic d; int idx;
    fixedPs = 6'd13; refillPs = 6'd13; entryHi = 48'h0000_0000_0137_4000;
    setHome();
    saAsid[2*ASID_W +: ASID_W] = curAsid + 10'd3;
    saAsid[4*ASID_W +: ASID_W] = curAsid + 10'd5;
    saAsid[7*ASID_W +: ASID_W] = curAsid + 10'd9;
    saGlobal[7] = 1'b1;
    @(negedge clk);
    refill(d, idx);
    check("R6 last foreign way", idx, 4 * SETS + expSet(entryHi, 13));
    check("R7 global foreign skipped", idx / SETS == 7, 0);
  endtask

  task automatic tSaRandom();
    logic d; int idx; int seen = 0;
    fixedPs = 6'd14; refillPs = 6'd14; entryHi = 48'h0000_0000_0ABC_8000;
    setHome();
    saGlobal[5] = 1'b1;
    saAsid[5*ASID_W +: ASID_W] = curAsid + 10'd7;
    for (int n = 0; n < 16; n++) begin
      for (int k = 0; k < n % 3; k++) @(negedge clk);
      refill(d, idx);
      seen |= 1 << (idx / SETS);
      if (idx % SETS != expSet(entryHi, 14) || idx >= SA_TOTAL)
        check("R9 random way in set", idx % SETS, expSet(entryHi, 14));
    end
    checks++;
    if ($countones(seen) < 2) begin
      errors++;
      $display("FAIL R9 random ways: actual=%0d distinct expected>=2", $countones(seen));
    end
  endtask

  task automatic tFaEmpty();
    logic d; int idx;
    fixedPs = 6'd13; refillPs = 6'd21; entryHi = 48'h0000_0000_4020_0000;
    setHome();
    faValid[30] = 1'b0; faValid[17] = 1'b0;
    faAsid[3*ASID_W +: ASID_W] = curAsid + 10'd2;
    @(negedge clk);
    refill(d, idx);
    check("R8 fa lowest empty", idx, SA_TOTAL + 17);
  endtask

  task automatic tFaForeign();
    logic d; int idx;
    fixedPs = 6'd13; refillPs = 6'd24; entryHi = 48'h0000_0000_8000_0000;
    setHome();
    faAsid[5*ASID_W +: ASID_W]  = curAsid + 10'd1;
    faAsid[40*ASID_W +: ASID_W] = curAsid + 10'd2;
    faAsid[44*ASID_W +: ASID_W] = curAsid + 10'd3;
    faGlobal[44] = 1'b1;
    @(negedge clk);
    refill(d, idx);
    check("R8 fa last foreign", idx, SA_TOTAL + 40);
  endtask

  task automatic tFaRandom();
    logic d; int idx; int lo = 9999; int hi = -1;
    fixedPs = 6'd13; refillPs = 6'd15; entryHi = 48'h0000_0000_0001_0000;
    setHome();
    for (int n = 0; n < 24; n++) begin
      @(negedge clk);
      refill(d, idx);
      if (idx < lo) lo = idx;
      if (idx > hi) hi = idx;
    end
    check("R9 fa random low bound", lo >= SA_TOTAL, 1);
    check("R9 fa random high bound", hi < SA_TOTAL + FA_DEPTH, 1);
    check("R9 fa random varies", hi > lo, 1);
  endtask

  task automatic tHold();
    logic d; int idx;
    fixedPs = 6'd13; refillPs = 6'd13; entryHi = 48'h0000_0000_0002_C000;
    setHome();
    saValid[2] = 1'b0;
    @(negedge clk);
    refill(d, idx);
    saValid = '1; saValid[0] = 1'b0; entryHi = 48'h0000_0000_0FF0_0000;
    refillPs = 6'd20;
    for (int k = 0; k < 4; k++) @(negedge clk);
    check("R10 index held", victimIdx, idx);
    check("R10 no pulse idle", doneValid, 0);
  endtask

  initial begin
    reqValid = 1'b0; rstN = 1'b0;
    entryHi = '0; refillPs = '0; fixedPs = '0; curAsid = 10'd37;
    setHome();
    repeat (3) @(negedge clk);
    check("R1 done in reset", doneValid, 0);
    rstN = 1'b1;
    tReset();
    tSetIndex();
    tSaEmpty();
    tSaForeign();
    tSaRandom();
    tFaEmpty();
    tFaForeign();
    tFaRandom();
    tHold();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule